// File: doc/BRIEF.md
# Round-Robin Multi-Queue Output Buffer

This block buffers the traffic of a single output port in a packet switch whose fabric can hand over several packets to that output in one time slot. The fabric presents up to `LANES` packets per cycle on parallel lanes, each lane qualified by its own valid bit. The valid packets are first packed towards the low positions and then rotated by a write pointer, so that consecutive packets land in consecutive physical banks. Each bank is an ordinary FIFO with one write port and one read port, so no storage element ever takes more than one write per cycle.

A single reader visits the banks in the same rotating order and hands out at most one packet per cycle, which is the link rate. Because writer and reader walk the banks in the same cyclic order, the set of banks behaves as one logical first-in first-out queue: packets leave in the order they arrived, across slots and, within a slot, in ascending lane order.

When the logical queue cannot take all arrivals of a slot, the packets that do not fit are discarded and a running drop count is kept. Per-bank full and empty flags are exported for the surrounding logic.

Top module: `obuf_rr_multiq`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `out_vld_o` is 0, `drop_cnt_o` is 0, every bit of `bank_empty_o` is 1 and every bit of `bank_full_o` is 0.
- R2: Within one slot, the valid lanes are taken in ascending lane index; the n-th valid packet (n counted from 0) is written to bank (write pointer + n) mod `LANES`, whatever lanes carry it.
- R3: A bank is never written while its full flag is set; bit b of `bank_full_o` is 1 exactly when bank b holds `BANK_DEPTH` packets.
- R4: Let `cap = LANES*BANK_DEPTH` and `occ` the packets held before a clock edge; of k valid arrivals, the first min(k, cap-occ) are stored, the remaining ones are dropped and `drop_cnt_o` grows by their number at that edge.
- R5: After each edge the write pointer has advanced by the number of stored packets, modulo `LANES`.
- R6: At most one packet is emitted per cycle; packets leave in global arrival order, and after each emitted packet the read pointer advances by one modulo `LANES`.
- R7: When the bank under the read pointer is empty, `out_vld_o` is 0 in the following cycle and the read pointer holds.
- R8: A packet stored at edge t into an empty buffer appears on `out_data_o` with `out_vld_o` = 1 after edge t+1.
- R9: Bit b of `bank_empty_o` is 1 exactly when bank b holds no packet; a bank is never flagged full and empty at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_vld_i | input | LANES | Per-lane arrival valid |
| lane_data_i | input | LANES*DATA_W | Lane payloads, lane j at bits [j*DATA_W +: DATA_W] |
| out_vld_o | output | 1 | Output packet valid |
| out_data_o | output | DATA_W | Output packet payload |
| bank_full_o | output | LANES | Per-bank full flags |
| bank_empty_o | output | LANES | Per-bank empty flags |
| drop_cnt_o | output | DROP_W | Running count of dropped packets, wraps |

## Verification
The hardest state to reach is an overflow that starts partway through a slot while the read pointer sits on a bank other than the write pointer, because the reader drains one packet per cycle and keeps the queue from filling unless arrivals outpace it. The bench drives several back-to-back slots with all lanes valid, so occupancy climbs by three per cycle until the last free positions are taken and the tail of a slot is discarded with the pointers offset. Long runs of random lane masks then mix partial slots, idle slots and drops, and every emitted packet is compared against a queue of expected identifiers kept from a bench-side occupancy count.

// File: rtl/obuf_pkg.sv
package obuf_pkg;

  // (base + off) mod m, used for pointer arithmetic
  function automatic int unsigned wrap_add(input int unsigned base,
                                           input int unsigned off,
                                           input int unsigned m);
    return (base + off) % m;
  endfunction

endpackage

// File: rtl/obuf_shift_conc.sv
module obuf_shift_conc
  import obuf_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 8,
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]        lane_vld_i,
  input  logic [LANES*DATA_W-1:0] lane_data_i,
  input  logic [IW-1:0]           wr_ptr_i,
  input  logic [LANES-1:0]        bank_full_i,
  output logic [LANES-1:0]        bank_we_o,
  output logic [LANES*DATA_W-1:0] bank_wdata_o,
  output logic [CW-1:0]           arr_cnt_o,
  output logic [CW-1:0]           acc_cnt_o
);

  logic [LANES-1:0][DATA_W-1:0] comp_data;
  logic [LANES-1:0]             comp_vld;

  // pack valid lanes to positions 0..k-1, lane order kept
  always_comb begin
    int unsigned pos;
    pos       = 0;
    comp_data = '0;
    comp_vld  = '0;
    for (int j = 0; j < LANES; j++) begin
      if (lane_vld_i[j]) begin
        comp_data[pos] = lane_data_i[j*DATA_W +: DATA_W];
        comp_vld[pos]  = 1'b1;
        pos            = pos + 1;
      end
    end
    arr_cnt_o = CW'(pos);
  end

  // accept a prefix of the packed packets; stop at first full target
  always_comb begin
    int unsigned acc;
    logic        go;
    acc = 0;
    go  = 1'b1;
    for (int p = 0; p < LANES; p++) begin
      if (go && comp_vld[p] && !bank_full_i[wrap_add(int'(wr_ptr_i), p, LANES)])
        acc = acc + 1;
      else
        go = 1'b0;
    end
    acc_cnt_o = CW'(acc);
  end

  // rotate packed positions onto banks
  always_comb begin
    for (int b = 0; b < LANES; b++) begin
      int unsigned rel;
      rel = wrap_add(b, LANES - int'(wr_ptr_i), LANES);
      bank_we_o[b]                      = (rel < int'(acc_cnt_o));
      bank_wdata_o[b*DATA_W +: DATA_W]  = comp_data[rel];
    end
  end

endmodule

// File: rtl/obuf_bank.sv
module obuf_bank #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              empty_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_idx, rd_idx;
  logic [NW-1:0]     cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] i);
    return (i == AW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_idx] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_idx <= '0;
      rd_idx <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_idx <= nxt(wr_idx);
      if (pop_i)  rd_idx <= nxt(rd_idx);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata_o = mem[rd_idx];
  assign full_o  = (cnt == NW'(DEPTH));
  assign empty_o = (cnt == '0);

endmodule

// File: rtl/obuf_rr_multiq.sv
module obuf_rr_multiq
  import obuf_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int DATA_W     = 8,
  parameter int BANK_DEPTH = 4,
  parameter int DROP_W     = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LANES-1:0]        lane_vld_i,
  input  logic [LANES*DATA_W-1:0] lane_data_i,
  output logic                    out_vld_o,
  output logic [DATA_W-1:0]       out_data_o,
  output logic [LANES-1:0]        bank_full_o,
  output logic [LANES-1:0]        bank_empty_o,
  output logic [DROP_W-1:0]       drop_cnt_o
);

  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int CW = $clog2(LANES + 1);

  logic [IW-1:0]                wr_ptr, rd_ptr;
  logic [LANES-1:0]             bank_we, bank_pop;
  logic [LANES*DATA_W-1:0]      bank_wdata;
  logic [LANES-1:0][DATA_W-1:0] bank_rdata;
  logic [CW-1:0]                arr_cnt, acc_cnt;
  logic                         rd_ok;

  obuf_shift_conc #(.LANES(LANES), .DATA_W(DATA_W)) u_conc (
    .lane_vld_i  (lane_vld_i),
    .lane_data_i (lane_data_i),
    .wr_ptr_i    (wr_ptr),
    .bank_full_i (bank_full_o),
    .bank_we_o   (bank_we),
    .bank_wdata_o(bank_wdata),
    .arr_cnt_o   (arr_cnt),
    .acc_cnt_o   (acc_cnt)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    assign bank_pop[b] = rd_ok && (rd_ptr == IW'(b));
    obuf_bank #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (bank_we[b]),
      .wdata_i(bank_wdata[b*DATA_W +: DATA_W]),
      .pop_i  (bank_pop[b]),
      .rdata_o(bank_rdata[b]),
      .full_o (bank_full_o[b]),
      .empty_o(bank_empty_o[b])
    );
  end

  assign rd_ok = !bank_empty_o[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      out_vld_o  <= 1'b0;
      out_data_o <= '0;
      drop_cnt_o <= '0;
    end else begin
      wr_ptr     <= IW'(wrap_add(int'(wr_ptr), int'(acc_cnt), LANES));
      drop_cnt_o <= drop_cnt_o + DROP_W'(arr_cnt - acc_cnt);
      out_vld_o  <= rd_ok;
      if (rd_ok) begin
        out_data_o <= bank_rdata[rd_ptr];
        rd_ptr     <= (rd_ptr == IW'(LANES - 1)) ? '0 : rd_ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/obuf_rr_multiq_chk.sv
module obuf_rr_multiq_chk #(
  parameter int LANES  = 4,
  parameter int DROP_W = 16,
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CW    = $clog2(LANES + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IW-1:0]     wr_ptr,
  input logic [IW-1:0]     rd_ptr,
  input logic [LANES-1:0]  bank_we,
  input logic [LANES-1:0]  bank_full_o,
  input logic [LANES-1:0]  bank_empty_o,
  input logic [CW-1:0]     arr_cnt,
  input logic [CW-1:0]     acc_cnt,
  input logic              out_vld_o,
  input logic [DROP_W-1:0] drop_cnt_o
);

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_no_full_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we & bank_full_o) == '0);

  assert_acc_le_arr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_cnt <= arr_cnt);

  assert_drop_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> drop_cnt_o == $past(drop_cnt_o) + DROP_W'($past(arr_cnt) - $past(acc_cnt)));

  assert_wr_ptr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> int'(wr_ptr) == (int'($past(wr_ptr)) + int'($past(acc_cnt))) % LANES);

  assert_rd_ptr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && out_vld_o) |-> int'(rd_ptr) == (int'($past(rd_ptr)) + 1) % LANES);

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !out_vld_o) |-> $stable(rd_ptr));

  assert_empty_no_out_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_empty_o[rd_ptr] |=> !out_vld_o);

  assert_flags_disjoint_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_full_o & bank_empty_o) == '0);

endmodule

bind obuf_rr_multiq obuf_rr_multiq_chk #(.LANES(LANES), .DROP_W(DROP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_ptr      (wr_ptr),
  .rd_ptr      (rd_ptr),
  .bank_we     (bank_we),
  .bank_full_o (bank_full_o),
  .bank_empty_o(bank_empty_o),
  .arr_cnt     (arr_cnt),
  .acc_cnt     (acc_cnt),
  .out_vld_o   (out_vld_o),
  .drop_cnt_o  (drop_cnt_o)
);

// File: tb/tb_obuf_rr_multiq.sv
`timescale 1ns/1ps
module tb_obuf_rr_multiq;

  localparam int LANES = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 4;
  localparam int DROPW = 16;
  localparam int CAP   = LANES * DEPTH;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [LANES-1:0]       lane_vld = '0;
  logic [LANES*DW-1:0]    lane_data = '0;
  logic                   out_vld;
  logic [DW-1:0]          out_data;
  logic [LANES-1:0]       bank_full, bank_empty;
  logic [DROPW-1:0]       drop_cnt;

  int n_chk = 0, n_fail = 0, occ = 0, drops = 0;
  logic [DW-1:0] next_id = 8'h01;
  logic [DW-1:0] expq[$];
  bit done = 0;

  always #5 clk = ~clk;

  obuf_rr_multiq #(.LANES(LANES), .DATA_W(DW), .BANK_DEPTH(DEPTH), .DROP_W(DROPW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lane_vld_i(lane_vld), .lane_data_i(lane_data),
    .out_vld_o(out_vld), .out_data_o(out_data), .bank_full_o(bank_full),
    .bank_empty_o(bank_empty), .drop_cnt_o(drop_cnt)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", what, act, exp, $time);
    end
  endtask

  // one slot: drive at negedge, predict, compare after the edge
  task automatic tick(input logic [LANES-1:0] mask);
    int k, acc, exp_full, exp_empty;
    bit ev;
    logic [DW-1:0] ed;
    logic [DW-1:0] ids [LANES];
    k = 0;
    ed = '0;
    for (int j = 0; j < LANES; j++) begin
      if (mask[j]) begin
        lane_data[j*DW +: DW] = next_id;
        ids[k] = next_id;
        next_id++;
        k++;
      end else lane_data[j*DW +: DW] = '0;
    end
    lane_vld = mask;
    acc = (k < CAP - occ) ? k : CAP - occ;
    ev  = (occ > 0);
    if (ev) ed = expq.pop_front();
    for (int i = 0; i < acc; i++) expq.push_back(ids[i]);
    occ   = occ + acc - (ev ? 1 : 0);
    drops = drops + k - acc;
    @(posedge clk);
    @(negedge clk);
    lane_vld = '0;
    check(out_vld == ev, "R7/R8 out_vld", int'(out_vld), int'(ev));
    if (ev) check(out_data == ed, "R2/R5/R6 out_data order", int'(out_data), int'(ed));
    check(int'(drop_cnt) == drops, "R4 drop_cnt", int'(drop_cnt), drops);
    exp_full  = (occ == CAP) ? LANES : ((occ / LANES == DEPTH - 1) ? occ % LANES : 0);
    exp_empty = (occ < LANES) ? LANES - occ : 0;
    check($countones(bank_full) == exp_full, "R3 full flags", $countones(bank_full), exp_full);
    check($countones(bank_empty) == exp_empty, "R9 empty flags", $countones(bank_empty), exp_empty);
  endtask

  task automatic drain();
    for (int i = 0; i < 24; i++) tick('0);
    check(bank_empty == '1, "R9 drained empty", int'(bank_empty), (1 << LANES) - 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_vld == 1'b0, "R1 out_vld in reset", int'(out_vld), 0);
    check(drop_cnt == '0, "R1 drop_cnt in reset", int'(drop_cnt), 0);
    check(bank_empty == '1, "R1 empty in reset", int'(bank_empty), (1 << LANES) - 1);
    check(bank_full == '0, "R1 full in reset", int'(bank_full), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_vld == 1'b0 && bank_empty == '1, "R1 after release", int'(out_vld), 0);
  endtask

  task automatic t_single();   // R8 latency
    tick(4'b0001);
    tick('0);
    drain();
  endtask

  task automatic t_sparse();   // R2 lane packing with rotation
    tick(4'b1010);
    tick(4'b0100);
    tick(4'b1001);
    tick(4'b1110);
    tick(4'b1000);
    drain();
  endtask

  task automatic t_overflow(); // R4 partial-slot drop
    for (int i = 0; i < 8; i++) tick('1);
    tick(4'b0110);
    tick('1);
    drain();
  endtask

  task automatic t_random();   // R6 global order under mixed bursts
    for (int i = 0; i < 300; i++) tick(LANES'($urandom % (1 << LANES)));
    drain();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_single();
    t_sparse();
    t_overflow();
    t_random();
    t_overflow();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule